// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

The block gathers interrupt requests and, for each of a small set of CPUs, offers one candidate: the pending, enabled interrupt aimed at that CPU with the best priority. Candidates appear on per-CPU ports as a valid flag, an interrupt ID and its priority value. A CPU takes the offered interrupt by pulsing its acknowledge input.

Software configures the block through a word-addressed register port. A CPU-number sideband comes with every access. IDs 0 to 15 are software-generated, IDs 16 to 31 are private to each CPU, and IDs from 32 upward are shared lines that are routed by a per-ID CPU bitmap. IDs 0 to 31 keep a separate copy of enable and pending state for every CPU, and the sideband picks the copy. The line count is `32*NWORDS`, and 2 ≤ NWORDS ≤ 31 keeps every ID below 1020.

Top module: `irq_dist`

## Requirements
- R1: After reset the forwarding switch, all enables, priorities and targets read 0, and no candidate is valid.
- R2: Word 0x001 is read-only and returns NWORDS-1 in bits 4:0, with all other bits 0.
- R3: Word 0x020+w is the set view of enable word w (IDs 32w..32w+31, bit b is ID 32w+b). Word 0x040+w is the clear view. A 1 written to the set view enables that ID, and a 1 written to the clear view disables it. 0 bits change nothing. Both views read the current enable bits.
- R4: Enable word 0 and the pending state of IDs 0..31 are kept separately for each CPU. An access touches the copy of the CPU on the sideband, and a CPU's private line drives only its own copy.
- R5: Word 0x080+k holds 2 bits per ID for IDs 16k..16k+15, with ID 16k+i at bits 2i+1:2i. The upper bit set means rising-edge sensitive and clear means level sensitive. The lower bit reads 0.
- R6: Trigger word 0 (IDs 0..15) always reads 0xAAAAAAAA and ignores writes.
- R7: Word 0x100+j holds the priority bytes and word 0x200+j holds the target bytes of IDs 4j..4j+3, with byte lane ID mod 4. Target bit n selects CPU n, and only NCPU bits are kept. Target words for IDs 0..31 read 0 and ignore writes.
- R8: Bit 0 of word 0x000 switches forwarding. While it is 0, no candidate is valid on any CPU.
- R9: A write to word 0x002 makes SGI ID wdata[3:0] pending on every CPU n whose bit wdata[16+n] is set. An acknowledge by that CPU of that ID clears it.
- R10: A level-sensitive interrupt is pending exactly while its line is high, and an acknowledge leaves it pending.
- R11: An edge-sensitive interrupt becomes pending on a 0-to-1 change of its line and stays pending until a CPU acknowledges that ID.
- R12: A CPU's candidate is chosen among its enabled, pending, targeted IDs. The numerically lowest priority value wins, and the lowest ID wins a tie. The candidate ports are registered and follow the state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data on reg_rdata after the next edge |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CPU_W | Number of the CPU making the access |
| reg_rdata | output | 32 | Registered read data |
| irq_shr | input | 32*NWORDS-32 | Shared lines, bit i is ID 32+i |
| irq_ppi | input | NCPU*16 | Private lines, bit 16c+k is ID 16+k of CPU c |
| cpu_ack | input | NCPU | Acknowledge of the CPU's current candidate |
| cand_valid | output | NCPU | Candidate present per CPU |
| cand_id | output | NCPU*10 | Candidate ID, CPU c in bits 10c+9:10c |
| cand_prio | output | NCPU*8 | Candidate priority, CPU c in bits 8c+7:8c |

## Verification
Every shared line is raised alone, which checks routing, the reported ID and the priority of each ID on each CPU. A run of arithmetic line masks, all lines at once, and a partly disabled set then compare the winner with a model in the bench that applies the lowest-value, lowest-ID rule. The priority pattern repeats every 16 IDs, so some masks contain ties. Single-line pulses and held lines set edge behaviour apart from level behaviour around an acknowledge. Software interrupts and private lines driven on one CPU check that the banked copies stay separate from the other CPU's.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    localparam logic [9:0] A_CTRL = 10'h000;
    localparam logic [9:0] A_TYPE = 10'h001;
    localparam logic [9:0] A_SGI  = 10'h002;
    localparam logic [9:0] A_CFG0 = 10'h080;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_SGI, RG_ENSET, RG_ENCLR, RG_CFG, RG_PRIO, RG_TGT
    } rg_e;

    typedef struct packed {
        rg_e        kind;
        logic [7:0] idx;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    function automatic dec_t decode(logic [9:0] a);
        dec_t d;
        d.kind = RG_NONE;
        d.idx  = a[7:0];
        case (a[9:8])
            2'b01: d.kind = RG_PRIO;
            2'b10: d.kind = RG_TGT;
            2'b00: begin
                if (a[7:5] == 3'b001) begin
                    d.kind = RG_ENSET;
                    d.idx  = {3'b0, a[4:0]};
                end else if (a[7:5] == 3'b010) begin
                    d.kind = RG_ENCLR;
                    d.idx  = {3'b0, a[4:0]};
                end else if (a[7:6] == 2'b10) begin
                    d.kind = RG_CFG;
                    d.idx  = {2'b0, a[5:0]};
                end else if (a == A_CTRL) d.kind = RG_CTRL;
                else if (a == A_TYPE) d.kind = RG_TYPE;
                else if (a == A_SGI)  d.kind = RG_SGI;
            end
            default: d.kind = RG_NONE;
        endcase
        return d;
    endfunction

    // upper bit of each 2-bit trigger pair
    function automatic logic [15:0] odd_bits(logic [31:0] w);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = w[2*i+1];
        return r;
    endfunction

    function automatic logic [31:0] as_pairs(logic [15:0] e);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) begin
            r[2*i+1] = e[i];
            r[2*i]   = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqd_pend.sv
module irqd_pend
    import irqd_pkg::*;
#(
    parameter int NCPU   = 2,
    parameter int NLINES = 64,
    localparam int NSHR  = NLINES - 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSHR-1:0]      irq_shr,
    input  logic [NCPU*16-1:0]   irq_ppi,
    input  logic [NLINES-17:0]   edge_cfg,   // bit k is ID 16+k
    input  logic [NCPU-1:0]      sgi_hit,
    input  logic [3:0]           sgi_id,
    input  logic [NCPU-1:0]      ack,
    input  logic [NCPU*ID_W-1:0] ack_id,
    output logic [NCPU*32-1:0]   pend_loc,
    output logic [NSHR-1:0]      pend_shr
);

    logic [NSHR-1:0]    shr_prev, shr_lat, shr_clr, shr_edge;
    logic [NCPU*16-1:0] ppi_prev, ppi_lat, ppi_clr, ppi_edge;
    logic [NCPU*16-1:0] sgi_lat, sgi_clr, sgi_set;

    assign shr_edge = edge_cfg[NLINES-17:16];
    assign ppi_edge = {NCPU{edge_cfg[15:0]}};

    always_comb begin
        shr_clr = '0;
        ppi_clr = '0;
        sgi_clr = '0;
        sgi_set = '0;
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NSHR; i++)
                if (ack[c] && ack_id[c*ID_W +: ID_W] == ID_W'(32 + i)) shr_clr[i] = 1'b1;
            for (int i = 0; i < 16; i++) begin
                if (ack[c] && ack_id[c*ID_W +: ID_W] == ID_W'(16 + i)) ppi_clr[c*16+i] = 1'b1;
                if (ack[c] && ack_id[c*ID_W +: ID_W] == ID_W'(i))      sgi_clr[c*16+i] = 1'b1;
                if (sgi_hit[c] && sgi_id == 4'(i))                     sgi_set[c*16+i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shr_prev <= '0;
            shr_lat  <= '0;
            ppi_prev <= '0;
            ppi_lat  <= '0;
            sgi_lat  <= '0;
        end else begin
            shr_prev <= irq_shr;
            ppi_prev <= irq_ppi;
            // a fresh rise wins over an acknowledge in the same cycle
            shr_lat  <= shr_edge & ((shr_lat & ~shr_clr) | (irq_shr & ~shr_prev));
            ppi_lat  <= ppi_edge & ((ppi_lat & ~ppi_clr) | (irq_ppi & ~ppi_prev));
            sgi_lat  <= (sgi_lat & ~sgi_clr) | sgi_set;
        end
    end

    assign pend_shr = (shr_edge & shr_lat) | (~shr_edge & irq_shr);

    always_comb begin
        for (int c = 0; c < NCPU; c++)
            pend_loc[c*32 +: 32] = {(ppi_edge[c*16 +: 16] & ppi_lat[c*16 +: 16]) |
                                    (~ppi_edge[c*16 +: 16] & irq_ppi[c*16 +: 16]),
                                    sgi_lat[c*16 +: 16]};
    end

    // R9: an SGI only turns pending after a register write asked for it
    a_r9_sgi_cause: assert property (@(posedge clk) disable iff (rst)
        (sgi_lat & ~$past(sgi_lat) & ~$past(sgi_set)) == '0);

    // R11: an edge latch only turns on after a 0-to-1 change of its line
    a_r11_edge_rise: assert property (@(posedge clk) disable iff (rst)
        (shr_lat & ~$past(shr_lat) & ~($past(irq_shr) & ~$past(shr_prev))) == '0);

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
#(
    parameter int NLINES = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NLINES-1:0]        elig,
    input  logic [NLINES*PRIO_W-1:0] prio,
    output cand_t                    cand
);

    cand_t best;

    // ascending scan with strict compare: lower ID keeps a tie
    always_comb begin
        best = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (elig[i] && (!best.valid || prio[i*PRIO_W +: PRIO_W] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = ID_W'(i);
                best.prio  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cand <= '0;
        else     cand <= best;
    end

    // R12: a candidate was eligible in the cycle it was chosen
    a_r12_pick_elig: assert property (@(posedge clk) disable iff (rst)
        cand.valid |-> |($past(elig) & (NLINES'(1) << cand.id)));

endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irqd_pkg::*;
#(
    parameter int  NCPU   = 2,
    parameter int  NWORDS = 2,
    localparam int NLINES = 32 * NWORDS,
    localparam int NSHR   = NLINES - 32,
    localparam int NPW    = NLINES / 4,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [9:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic [CPU_W-1:0]       reg_cpu,
    output logic [31:0]            reg_rdata,
    input  logic [NSHR-1:0]        irq_shr,
    input  logic [NCPU*16-1:0]     irq_ppi,
    input  logic [NCPU-1:0]        cpu_ack,
    output logic [NCPU-1:0]        cand_valid,
    output logic [NCPU*ID_W-1:0]   cand_id,
    output logic [NCPU*PRIO_W-1:0] cand_prio
);

    dec_t dec;
    assign dec = decode(reg_addr);

    logic                              ctrl_en;
    logic [NCPU-1:0][31:0]             en_loc;
    logic [NWORDS-1:1][31:0]           en_w;
    logic [2*NWORDS-1:1][15:0]         cfg_w;
    logic [NPW-1:0][31:0]              prio_w;
    logic [NSHR-1:0][NCPU-1:0]         tgt_s;
    logic [31:0]                       rd_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            en_loc  <= '0;
            en_w    <= '0;
            cfg_w   <= '0;
            prio_w  <= '0;
            tgt_s   <= '0;
        end else if (reg_wr) begin
            case (dec.kind)
                RG_CTRL: ctrl_en <= reg_wdata[0];
                RG_ENSET, RG_ENCLR: begin
                    for (int c = 0; c < NCPU; c++)
                        if (dec.idx == '0 && reg_cpu == CPU_W'(c))
                            en_loc[c] <= (dec.kind == RG_ENSET) ? (en_loc[c] | reg_wdata)
                                                                : (en_loc[c] & ~reg_wdata);
                    for (int w = 1; w < NWORDS; w++)
                        if (dec.idx == 8'(w))
                            en_w[w] <= (dec.kind == RG_ENSET) ? (en_w[w] | reg_wdata)
                                                              : (en_w[w] & ~reg_wdata);
                end
                RG_CFG:
                    for (int k = 1; k < 2*NWORDS; k++)
                        if (dec.idx == 8'(k)) cfg_w[k] <= odd_bits(reg_wdata);
                RG_PRIO:
                    for (int j = 0; j < NPW; j++)
                        if (dec.idx == 8'(j)) prio_w[j] <= reg_wdata;
                RG_TGT:
                    for (int j = 8; j < NPW; j++)
                        if (dec.idx == 8'(j))
                            for (int l = 0; l < 4; l++)
                                tgt_s[j*4+l-32] <= reg_wdata[l*8 +: NCPU];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            RG_CTRL: rd_val = {31'b0, ctrl_en};
            RG_TYPE: rd_val = 32'(NWORDS - 1);
            RG_ENSET, RG_ENCLR: begin
                for (int c = 0; c < NCPU; c++)
                    if (dec.idx == '0 && reg_cpu == CPU_W'(c)) rd_val = en_loc[c];
                for (int w = 1; w < NWORDS; w++)
                    if (dec.idx == 8'(w)) rd_val = en_w[w];
            end
            RG_CFG: begin
                if (dec.idx == '0) rd_val = 32'hAAAA_AAAA;
                for (int k = 1; k < 2*NWORDS; k++)
                    if (dec.idx == 8'(k)) rd_val = as_pairs(cfg_w[k]);
            end
            RG_PRIO:
                for (int j = 0; j < NPW; j++)
                    if (dec.idx == 8'(j)) rd_val = prio_w[j];
            RG_TGT:
                for (int j = 8; j < NPW; j++)
                    if (dec.idx == 8'(j))
                        for (int l = 0; l < 4; l++)
                            rd_val[l*8 +: NCPU] = tgt_s[j*4+l-32];
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    // pending state
    logic [NCPU-1:0]      sgi_hit;
    logic [NCPU*32-1:0]   pend_loc;
    logic [NSHR-1:0]      pend_shr;
    logic [NSHR-1:0]      en_shr;

    assign en_shr = en_w;

    always_comb begin
        for (int c = 0; c < NCPU; c++)
            sgi_hit[c] = reg_wr && dec.kind == RG_SGI && reg_wdata[16+c];
    end

    irqd_pend #(.NCPU(NCPU), .NLINES(NLINES)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .irq_shr  (irq_shr),
        .irq_ppi  (irq_ppi),
        .edge_cfg (cfg_w),
        .sgi_hit  (sgi_hit),
        .sgi_id   (reg_wdata[3:0]),
        .ack      (cpu_ack),
        .ack_id   (cand_id),
        .pend_loc (pend_loc),
        .pend_shr (pend_shr)
    );

    // eligibility and per-CPU selection
    logic [NCPU-1:0][NLINES-1:0] elig;
    cand_t [NCPU-1:0]            cand;

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < 32; i++)
                elig[c][i] = ctrl_en & en_loc[c][i] & pend_loc[c*32+i];
            for (int i = 0; i < NSHR; i++)
                elig[c][32+i] = ctrl_en & en_shr[i] & pend_shr[i] & tgt_s[i][c];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irqd_pick #(.NLINES(NLINES)) u_pick (
            .clk  (clk),
            .rst  (rst),
            .elig (elig[c]),
            .prio (prio_w),
            .cand (cand[c])
        );
        assign cand_valid[c]                = cand[c].valid;
        assign cand_id[c*ID_W +: ID_W]      = cand[c].id;
        assign cand_prio[c*PRIO_W +: PRIO_W] = cand[c].prio;
    end

    // R8: with forwarding off, nothing is offered one cycle later
    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> cand_valid == '0);

    // R6: trigger word 0 is fixed
    a_r6_sgi_cfg: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_CFG0) |=> reg_rdata == 32'hAAAA_AAAA);

    // R2: line count report
    a_r2_type: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_TYPE) |=> reg_rdata == 32'(NWORDS - 1));

endmodule

// File: tb/sim_irq_dist.sv
module sim_irq_dist;

    localparam int CLK_NS = 10;
    localparam int NCPU   = 2;
    localparam int NWORDS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [0:0]  reg_cpu = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_shr = '0;
    logic [31:0] irq_ppi = '0;
    logic [1:0]  cpu_ack = '0;
    logic [1:0]  cand_valid;
    logic [19:0] cand_id;
    logic [15:0] cand_prio;

    int total = 0, bad = 0;

    irq_dist #(.NCPU(NCPU), .NWORDS(NWORDS)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .reg_rdata(reg_rdata),
        .irq_shr(irq_shr), .irq_ppi(irq_ppi), .cpu_ack(cpu_ack),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int pf(input int i); return (i*5 + 3) % 16; endfunction
    function automatic int tf(input int i); return (i % 3) + 1;    endfunction

    // {valid, id, prio} expected on CPU c for shared lines in m
    function automatic logic [18:0] model(input logic [31:0] m, input int c);
        logic [18:0] r = '0;
        for (int i = 32; i < 64; i++)
            if (m[i-32] && tf(i)[c] && (!r[18] || pf(i) < int'(r[7:0])))
                r = {1'b1, 10'(i), 8'(pf(i))};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int c, input logic [9:0] a, input logic [31:0] d);
        reg_cpu = 1'(c); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int c, input logic [9:0] a, output logic [31:0] d);
        reg_cpu = 1'(c); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic settle; repeat (3) @(negedge clk); endtask

    task automatic chk_cand(input string tag, input int c, input logic [18:0] e);
        logic [18:0] a;
        a = {cand_valid[c], cand_id[c*10 +: 10], cand_prio[c*8 +: 8]};
        if (!e[18]) a = {cand_valid[c], 18'b0};
        chk(tag, 32'(a), 32'(e));
    endtask

    task automatic pulse_ack(input int c);
        cpu_ack[c] = 1'b1;
        @(negedge clk);
        cpu_ack = '0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(0, 10'h000, d); chk("R1 ctrl", d, 0);
        rd(0, 10'h021, d); chk("R1 enable", d, 0);
        rd(0, 10'h108, d); chk("R1 prio", d, 0);
        rd(0, 10'h208, d); chk("R1 target", d, 0);
        chk("R1 cand", 32'(cand_valid), 0);
        // R2
        rd(1, 10'h001, d); chk("R2 type", d, 32'(NWORDS-1));

        // setup priorities, targets, enables
        for (int j = 8; j < 16; j++) begin
            logic [31:0] pw, tw;
            for (int l = 0; l < 4; l++) begin
                pw[l*8 +: 8] = 8'(pf(4*j+l));
                tw[l*8 +: 8] = 8'(tf(4*j+l));
            end
            wr(0, 10'(10'h100 + j), pw);
            wr(0, 10'(10'h200 + j), tw);
        end
        rd(0, 10'h109, d); chk("R7 prio lanes", d, {8'(pf(39)), 8'(pf(38)), 8'(pf(37)), 8'(pf(36))});
        rd(0, 10'h20A, d); chk("R7 target lanes", d, {8'(tf(43)), 8'(tf(42)), 8'(tf(41)), 8'(tf(40))});
        wr(0, 10'h200, 32'hFFFF_FFFF);
        rd(0, 10'h200, d); chk("R7 local target ignored", d, 0);
        wr(0, 10'h021, 32'hFFFF_FFFF);
        wr(0, 10'h000, 32'h1);

        // R12 single-line sweep
        for (int i = 32; i < 64; i++) begin
            irq_shr = 32'(1) << (i - 32);
            settle();
            for (int c = 0; c < 2; c++) chk_cand($sformatf("R12 line %0d cpu%0d", i, c), c, model(irq_shr, c));
        end
        // R12 mixed masks, includes ties
        m = 32'h1234_5678;
        for (int p = 0; p < 16; p++) begin
            m = m * 32'd1103515245 + 32'd12345;
            irq_shr = m;
            settle();
            for (int c = 0; c < 2; c++) chk_cand($sformatf("R12 mask %h cpu%0d", m, c), c, model(m, c));
        end
        irq_shr = '1;
        settle();
        for (int c = 0; c < 2; c++) chk_cand("R12 all lines tie", c, model(32'hFFFF_FFFF, c));

        // R3 clear view
        wr(0, 10'h041, 32'h0000_FFFF);
        rd(0, 10'h021, d); chk("R3 set view", d, 32'hFFFF_0000);
        rd(0, 10'h041, d); chk("R3 clear view", d, 32'hFFFF_0000);
        settle();
        for (int c = 0; c < 2; c++) chk_cand("R3 partly disabled", c, model(32'hFFFF_0000, c));

        // R8 forwarding off
        wr(0, 10'h000, 32'h0);
        settle();
        chk("R8 gate", 32'(cand_valid), 0);
        wr(0, 10'h000, 32'h1);
        wr(0, 10'h021, 32'hFFFF_FFFF);
        irq_shr = '0;
        settle();
        chk("R12 idle", 32'(cand_valid), 0);

        // R5/R6 trigger words
        wr(0, 10'h080, 32'h0);
        rd(0, 10'h080, d); chk("R6 sgi cfg", d, 32'hAAAA_AAAA);
        wr(0, 10'h081, 32'hFFFF_FFFF);
        rd(0, 10'h081, d); chk("R5 upper bits only", d, 32'hAAAA_AAAA);
        wr(0, 10'h081, 32'h0);
        wr(0, 10'h082, 32'h0002_0000);
        rd(1, 10'h082, d); chk("R5 edge id40", d, 32'h0002_0000);

        // R11 edge id 40 -> cpu1 only
        irq_shr[8] = 1'b1; @(negedge clk); irq_shr[8] = 1'b0;
        settle();
        chk_cand("R11 edge latched cpu1", 1, {1'b1, 10'd40, 8'(pf(40))});
        chk_cand("R11 edge not on cpu0", 0, 19'b0);
        pulse_ack(1);
        settle();
        chk_cand("R11 ack clears", 1, 19'b0);

        // R10 level id 41 -> both
        irq_shr[9] = 1'b1;
        settle();
        chk_cand("R10 level", 0, {1'b1, 10'd41, 8'(pf(41))});
        pulse_ack(0);
        settle();
        chk_cand("R10 ack no effect", 0, {1'b1, 10'd41, 8'(pf(41))});
        irq_shr[9] = 1'b0;
        settle();
        chk_cand("R10 line low", 0, 19'b0);

        // R4 banked enables
        wr(1, 10'h020, 32'h0000_0020);
        rd(0, 10'h020, d); chk("R4 cpu0 copy", d, 0);
        rd(1, 10'h020, d); chk("R4 cpu1 copy", d, 32'h0000_0020);

        // R9 SGI 5 to cpu0 and cpu1, only cpu1 has it enabled
        wr(0, 10'h002, 32'h0003_0005);
        settle();
        chk_cand("R9 sgi cpu1", 1, {1'b1, 10'd5, 8'd0});
        chk_cand("R9 sgi cpu0 disabled", 0, 19'b0);
        pulse_ack(1);
        settle();
        chk_cand("R9 ack clears", 1, 19'b0);
        // cpu0 copy is still pending: enabling it now exposes it
        wr(0, 10'h020, 32'h0000_0020);
        settle();
        chk_cand("R9 cpu0 copy kept", 0, {1'b1, 10'd5, 8'd0});
        pulse_ack(0);
        wr(0, 10'h040, 32'h0000_0020);

        // R4 private lines: ID 20 on both, enabled on cpu0 only
        wr(0, 10'h020, 32'h0010_0000);
        irq_ppi = 32'h0010_0010;
        settle();
        chk_cand("R4 ppi cpu0", 0, {1'b1, 10'd20, 8'd0});
        chk_cand("R4 ppi cpu1 disabled", 1, 19'b0);
        irq_ppi = '0;
        settle();
        chk_cand("R4 ppi drop", 0, 19'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule